// File: doc/BRIEF.md
# Signed/Unsigned Radix-4 Booth Partial-Product Generator

This block is the first stage of a parallel multiplier. It takes an N-bit multiplicand, an N-bit multiplier and one mode pin, and forms every radix-4 Booth partial-product row at once in pure combinational logic. Each row comes with one negate bit. That bit must be added at the row's least significant position by the reduction tree that follows. The reduction tree and the final carry-propagate adder are not part of this block.

The multiplier is padded with a zero below its bit 0. It is then cut into overlapping three-bit groups, one group per row. Each group is decoded into three controls: select the multiplicand, select twice the multiplicand, and negate. Each row bit is then picked by a small four-way selection from the multiplicand bits, XORed with the top bit of the group. The mode pin decides how both operands are widened by two bits, with zeros or with copies of their sign bit. This lets the same array serve both unsigned and signed two's-complement multiplication.

The block has no clock and no handshake. Its outputs follow its inputs combinationally. A downstream stage can register the inputs or the outputs as its own timing needs.

Top module: `booth_pp_gen`

## Requirements
- R1: Row k is built from the multiplier group g = (b[2k+1], b[2k], b[2k-1]), where b[-1] = 0. The group maps to a digit d as follows: 000→0, 001→+1, 010→+1, 011→+2, 100→−2, 101→−1, 110→−1, 111→0. Let A be the extended multiplicand. Then (row_k + neg_k) mod 2^(N+2) equals (d·A) mod 2^(N+2).
- R2: For a negative digit, row k is the bitwise complement of |d|·A over N+2 bits. For a digit of zero or above, row k equals d·A over N+2 bits. A zero digit therefore gives an all-zero row.
- R3: neg_k is 1 exactly for the groups 100, 101 and 110. It is 0 for the other five groups, including 111.
- R4: With signed_mode_i = 0, both operands are zero-extended by two bits. The top row (k = N/2) then equals the multiplicand zero-extended when b[N-1] = 1, and is zero otherwise, and its negate bit is 0.
- R5: With signed_mode_i = 1, both operands are widened with copies of their bit N-1. The top row's group is then 000 or 111, so the top row is zero and its negate bit is 0.
- R6: There are N/2+1 rows. Row k sits at rows_o[k*(N+2) +: N+2] and neg_k at neg_o[k]. Sign-extend each row as an (N+2)-bit two's-complement value, add its negate bit, and weight the result by 4^k. The total, mod 2^(2N), equals a·b: unsigned×unsigned in mode 0, signed×signed in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | Multiplicand |
| b_i | input | N | Multiplier, recoded in groups of three bits |
| signed_mode_i | input | 1 | 0: unsigned operands, 1: signed two's-complement operands |
| rows_o | output | (N/2+1)*(N+2) | Partial-product rows; row k occupies bits k*(N+2) upward |
| neg_o | output | N/2+1 | Per-row +1 to be added at that row's least significant bit |

## Verification
The checker's properties assume two-state operands and an even N. They also assume the outputs are sampled only after the inputs have settled, since the block is purely combinational. The bench uses a six-bit configuration and changes inputs only at rising edges of its pacing clock. It samples at the falling edge. Every multiplicand, multiplier and mode combination is driven, so every group pattern meets every multiplicand value, including the most negative value and all ones, in both extension modes.

// File: rtl/booth_pp_pkg.sv
package booth_pp_pkg;

  // Decoded controls of one multiplier group
  typedef struct packed {
    logic one;  // pick the multiplicand
    logic two;  // pick the multiplicand shifted left by one
    logic neg;  // +1 owed at the row's least significant bit
    logic inv;  // complement the picked bits
  } booth_ctl_t;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'b00,
    SEL_ONE  = 2'b01,
    SEL_TWO  = 2'b10,
    SEL_BOTH = 2'b11
  } booth_sel_e;

  function automatic booth_sel_e sel_of(booth_ctl_t c);
    return booth_sel_e'({c.two, c.one});
  endfunction

endpackage

// File: rtl/booth_operand_extend.sv
module booth_operand_extend #(
  parameter int N   = 16,
  parameter int EXT = 2
) (
  input  logic [N-1:0]     op_i,
  input  logic             signed_mode_i,
  output logic [N+EXT-1:0] op_o
);

  logic fill;

  assign fill = signed_mode_i & op_i[N-1];
  assign op_o = {{EXT{fill}}, op_i};

endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pp_pkg::*;
(
  input  logic [2:0]  grp_i,
  output booth_ctl_t  ctl_o
);

  always_comb begin
    ctl_o.one = grp_i[1] ^ grp_i[0];
    ctl_o.two = (grp_i == 3'b011) | (grp_i == 3'b100);
    ctl_o.neg = grp_i[2] & ~(grp_i[1] & grp_i[0]);
    ctl_o.inv = grp_i[2];
  end

endmodule

// File: rtl/booth_row_select.sv
module booth_row_select
  import booth_pp_pkg::*;
#(
  parameter int RW = 18
) (
  input  logic [RW-1:0] a_ext_i,
  input  booth_ctl_t    ctl_i,
  output logic [RW-1:0] row_o
);

  logic [RW-1:0] x;
  booth_sel_e    sel;

  assign x   = a_ext_i ^ {RW{ctl_i.inv}};
  assign sel = sel_of(ctl_i);

  for (genvar j = 0; j < RW; j++) begin : g_bit
    logic lower;
    if (j == 0) begin : g_lsb
      assign lower = ctl_i.inv;
    end else begin : g_mid
      assign lower = x[j-1];
    end

    always_comb begin
      unique case (sel)
        SEL_ONE:  row_o[j] = x[j];
        SEL_TWO:  row_o[j] = lower;
        default:  row_o[j] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]               a_i,
  input  logic [N-1:0]               b_i,
  input  logic                       signed_mode_i,
  output logic [(N/2+1)*(N+2)-1:0]   rows_o,
  output logic [N/2:0]               neg_o
);

  localparam int RW = N + 2;
  localparam int NR = N / 2 + 1;

  logic [RW-1:0] a_ext;
  logic [RW-1:0] b_ext;
  logic [RW:0]   b_pad;

  booth_operand_extend #(.N(N), .EXT(2)) u_ext_a (
    .op_i          (a_i),
    .signed_mode_i (signed_mode_i),
    .op_o          (a_ext)
  );

  booth_operand_extend #(.N(N), .EXT(2)) u_ext_b (
    .op_i          (b_i),
    .signed_mode_i (signed_mode_i),
    .op_o          (b_ext)
  );

  assign b_pad = {b_ext, 1'b0};

  for (genvar k = 0; k < NR; k++) begin : g_row
    booth_ctl_t ctl;

    booth_recode u_rec (
      .grp_i (b_pad[2*k +: 3]),
      .ctl_o (ctl)
    );

    booth_row_select #(.RW(RW)) u_sel (
      .a_ext_i (a_ext),
      .ctl_i   (ctl),
      .row_o   (rows_o[k*RW +: RW])
    );

    assign neg_o[k] = ctl.neg;
  end

endmodule

// File: rtl/booth_pp_chk.sv
module booth_pp_chk #(
  parameter int N = 16
) (
  input logic [N-1:0]               a_i,
  input logic [N-1:0]               b_i,
  input logic                       signed_mode_i,
  input logic [(N/2+1)*(N+2)-1:0]   rows_o,
  input logic [N/2:0]               neg_o
);

  localparam int RW = N + 2;
  localparam int NR = N / 2 + 1;

  logic [RW-1:0] a_w;
  logic [RW:0]   b_w;

  assign a_w = signed_mode_i ? {{2{a_i[N-1]}}, a_i} : {2'b00, a_i};
  assign b_w = signed_mode_i ? {{2{b_i[N-1]}}, b_i, 1'b0} : {2'b00, b_i, 1'b0};

  always_comb begin
    for (int k = 0; k < NR; k++) begin
      logic [2:0]    g;
      logic [RW-1:0] row;
      logic [RW-1:0] want;
      logic [RW-1:0] got;
      g   = b_w[2*k +: 3];
      row = rows_o[k*RW +: RW];
      case (g)
        3'b001, 3'b010: want = a_w;
        3'b011:         want = a_w << 1;
        3'b100:         want = RW'(0) - (a_w << 1);
        3'b101, 3'b110: want = RW'(0) - a_w;
        default:        want = '0;
      endcase
      got = row + RW'(neg_o[k]);
      // R1
      row_value_chk: assert (got == want);
      // R3
      neg_pattern_chk: assert (neg_o[k] == (g == 3'b100 || g == 3'b101 || g == 3'b110));
    end
  end

  always_comb begin
    logic [RW-1:0] top;
    top = rows_o[(NR-1)*RW +: RW];
    if (!signed_mode_i) begin
      // R4
      unsigned_top_chk: assert (!neg_o[NR-1] && top == (b_i[N-1] ? {2'b00, a_i} : RW'(0)));
    end else begin
      // R5
      signed_top_chk: assert (!neg_o[NR-1] && top == RW'(0));
    end
  end

endmodule

bind booth_pp_gen booth_pp_chk #(.N(N)) u_chk (
  .a_i           (a_i),
  .b_i           (b_i),
  .signed_mode_i (signed_mode_i),
  .rows_o        (rows_o),
  .neg_o         (neg_o)
);

// File: tb/sim_booth_pp_gen.sv
module sim_booth_pp_gen;

  localparam int W          = 6;
  localparam int RW         = W + 2;
  localparam int NR         = W / 2 + 1;
  localparam int CLK_PERIOD = 10;
  localparam longint RM     = (64'sd1 << RW) - 1;
  localparam longint PM     = (64'sd1 << (2*W)) - 1;

  logic                 clk = 1'b0;
  logic [W-1:0]         a = '0;
  logic [W-1:0]         b = '0;
  logic                 md = 1'b0;
  logic [NR*RW-1:0]     rows;
  logic [NR-1:0]        negs;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_pp_gen #(.N(W)) u0 (
    .a_i           (a),
    .b_i           (b),
    .signed_mode_i (md),
    .rows_o        (rows),
    .neg_o         (negs)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d mode=%0d actual=%0d expected=%0d", tag, a, b, md, act, exp);
    end
  endtask

  task automatic evaluate();
    longint av, bv, sum;
    logic [W+1:0] be;
    av  = md ? longint'($signed(a)) : longint'(a);
    bv  = md ? longint'($signed(b)) : longint'(b);
    be  = md ? {{2{b[W-1]}}, b} : {2'b00, b};
    sum = 0;
    for (int k = 0; k < NR; k++) begin
      logic [2:0] t;
      longint d, rv, nb, mag, e2, sv;
      t  = {be[2*k+1], be[2*k], (k == 0) ? 1'b0 : be[2*k-1]};
      case (t)
        3'd1, 3'd2: d = 1;
        3'd3:       d = 2;
        3'd4:       d = -2;
        3'd5, 3'd6: d = -1;
        default:    d = 0;
      endcase
      rv = longint'(rows[k*RW +: RW]);
      nb = longint'(negs[k]);
      // R1: digit times multiplicand
      chk(((rv + nb) & RM) == ((d * av) & RM), "R1 row+neg", (rv + nb) & RM, (d * av) & RM);
      // R2: complement form of negative rows
      mag = (d < 0 ? -d : d) * av;
      e2  = (d < 0) ? ((~mag) & RM) : (mag & RM);
      chk(rv == e2, "R2 row bits", rv, e2);
      // R3: negate bit pattern
      chk(nb == longint'(t == 3'd4 || t == 3'd5 || t == 3'd6), "R3 neg bit", nb,
          longint'(t == 3'd4 || t == 3'd5 || t == 3'd6));
      if (k == NR - 1) begin
        if (!md) begin
          // R4: zero extension in unsigned mode
          chk(rv == (b[W-1] ? longint'(a) : 0) && nb == 0, "R4 top row", rv,
              b[W-1] ? longint'(a) : 0);
        end else begin
          // R5: sign extension in signed mode
          chk(rv == 0 && nb == 0, "R5 top row", rv, 0);
        end
      end
      sv  = (rv >= (64'sd1 << (RW-1))) ? rv - (64'sd1 << RW) : rv;
      sum = sum + ((sv + nb) <<< (2*k));
    end
    // R6: weighted sum of rows is the product
    chk((sum & PM) == ((av * bv) & PM), "R6 product", sum & PM, (av * bv) & PM);
  endtask

  initial begin
    // Reset-like state: all-zero inputs give zero rows and no negate bits (R3)
    #1;
    chk(rows == '0 && negs == '0, "R3 idle zero", longint'(rows), 0);
    for (int m = 0; m < 2; m++) begin
      for (int ai = 0; ai < (1 << W); ai++) begin
        for (int bi = 0; bi < (1 << W); bi++) begin
          @(posedge clk);
          a  = W'(ai);
          b  = W'(bi);
          md = m[0];
          @(negedge clk);
          evaluate();
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule